// File: doc/BRIEF.md
# Masked-Write Soft Reset Controller

This block holds a small bank of software-controlled reset registers. Each register drives a contiguous group of active-high reset outputs, and the outputs come straight from flip-flops. Software reaches the bank through a simple register bus: a byte address, a 32-bit write word with a write strobe, and a 32-bit read word that follows the address combinationally. Register `i` sits at byte address `4*i`. The two lowest address bits play no part in decoding.

A build-time parameter chooses one of two write modes. In masked mode each register holds 16 reset bits. The upper half of a written word acts as a per-bit write enable for the lower half, so software can set or clear a single reset in one write without reading first. In plain mode each register is a full 32-bit word. Software changes one reset by reading the word, editing one bit and writing the whole word back.

Reset line `N` is bit `N % P` of register `N / P`, where `P` is 16 in masked mode and 32 in plain mode. The output vector has `NUM_REGS * P` lines.

Top module: `srst_ctrl`

## Requirements
- R1: While `rst_n` is low, every reset output is 0 and every register reads as 0. The first edge after release still shows all outputs at 0.
- R2: Output line `N` is bit `N % P` of the register at byte address `4*(N / P)`. A write changes the outputs on the clock edge that samples the strobe.
- R3: In masked mode, a write with data bit k = 1 and mask bit k+16 = 1 sets stored bit k to 1, which asserts that output.
- R4: In masked mode, a write with mask bit k+16 = 1 and data bit k = 0 clears stored bit k to 0, which deasserts that output.
- R5: In masked mode, a stored bit whose mask bit k+16 is 0 keeps its value, whatever data bit k holds.
- R6: In masked mode, a read returns the 16 stored bits in bits [15:0] and zeros in bits [31:16].
- R7: In plain mode, a write replaces all 32 bits of the addressed register, and a read returns the same 32 bits. A read-modify-write of one bit therefore changes only that output.
- R8: A write whose word index (address bits above bit 1) is `NUM_REGS` or more changes no output. A read from such an address returns 0.
- R9: Address bits [1:0] are ignored: an unaligned address selects the register of its containing word.
- R10: A write changes no register other than the addressed one, and no output changes in a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write word |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read word for `bus_addr` |
| rst_out | output | NUM_REGS*P | Registered reset outputs, active high |

## Verification
One masked instance and one plain instance share the same bus stimulus. Directed writes cover these cases:
- Mask and data both set, which separates a working set from a dropped write.
- Data with an empty mask, which catches a lower half that writes through without its enable.
- Mask with zero data, which separates a clear from a hold.
- An all-ones word, whose read-back exposes upper-half leakage in masked mode.

Writes to the last register and beyond it, and to unaligned addresses, separate off-by-one and alignment errors in the decode. A read-modify-write on the plain instance shows that a single-bit edit moves only its own line. A long run of random addresses, data and strobes then compares every output bit against the reference model on every clock.

// File: rtl/srst_pkg.sv
`timescale 1ns/1ps
package srst_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned HALF_W     = 16;
    localparam int unsigned BYTE_STEP  = 4;
    localparam int unsigned ADDR_LSB   = 2;

    // Half-word enable merge: upper half of the write word enables lower half.
    function automatic logic [HALF_W-1:0] half_merge(
        input logic [HALF_W-1:0] cur,
        input logic [WORD_W-1:0] w
    );
        logic [HALF_W-1:0] en;
        en = w[WORD_W-1:HALF_W];
        return (cur & ~en) | (w[HALF_W-1:0] & en);
    endfunction

endpackage

// File: rtl/srst_decode.sv
`timescale 1ns/1ps
module srst_decode #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned ADDR_W   = 8,
    localparam int unsigned IDX_W   = ADDR_W - srst_pkg::ADDR_LSB
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    output logic [IDX_W-1:0]    word_idx,
    output logic                in_range,
    output logic [NUM_REGS-1:0] wr_sel
);
    logic unused_lsb;

    assign unused_lsb = ^addr[srst_pkg::ADDR_LSB-1:0];
    assign word_idx   = addr[ADDR_W-1:srst_pkg::ADDR_LSB];
    assign in_range   = ({1'b0, word_idx} < (IDX_W+1)'(NUM_REGS));

    always_comb begin
        for (int i = 0; i < int'(NUM_REGS); i++) begin
            wr_sel[i] = we && in_range && (word_idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/srst_reg.sv
`timescale 1ns/1ps
module srst_reg #(
    parameter bit           MASK_MODE = 1'b1,
    parameter int unsigned  PER       = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [srst_pkg::WORD_W-1:0] wdata,
    output logic [PER-1:0]              bits
);
    typedef struct packed {
        logic [PER-1:0] bits;
    } reg_state_t;

    reg_state_t st_d, st_q;

    generate
        if (MASK_MODE) begin : g_masked
            always_comb begin
                st_d = st_q;
                if (wr_en) begin
                    st_d.bits = srst_pkg::half_merge(st_q.bits, wdata);
                end
            end
        end else begin : g_plain
            always_comb begin
                st_d = st_q;
                if (wr_en) begin
                    st_d.bits = wdata[PER-1:0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.bits;
endmodule

// File: rtl/srst_rdmux.sv
`timescale 1ns/1ps
module srst_rdmux #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned PER      = 16,
    parameter int unsigned IDX_W    = 6
) (
    input  logic [NUM_REGS*PER-1:0]     flat,
    input  logic [IDX_W-1:0]            word_idx,
    input  logic                        in_range,
    output logic [srst_pkg::WORD_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < int'(NUM_REGS); i++) begin
            if (in_range && (word_idx == IDX_W'(i))) begin
                rdata[PER-1:0] = flat[i*PER +: PER];
            end
        end
    end
endmodule

// File: rtl/srst_ctrl.sv
`timescale 1ns/1ps
module srst_ctrl #(
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned ADDR_W    = 8,
    parameter bit          MASK_MODE = 1'b1,
    localparam int unsigned PER      = MASK_MODE ? srst_pkg::HALF_W : srst_pkg::WORD_W,
    localparam int unsigned NUM_RST  = NUM_REGS * PER,
    localparam int unsigned IDX_W    = ADDR_W - srst_pkg::ADDR_LSB
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [srst_pkg::WORD_W-1:0] bus_wdata,
    input  logic                        bus_we,
    output logic [srst_pkg::WORD_W-1:0] bus_rdata,
    output logic [NUM_RST-1:0]          rst_out
);
    logic [IDX_W-1:0]    word_idx;
    logic                in_range;
    logic [NUM_REGS-1:0] wr_sel;
    logic [NUM_RST-1:0]  flat;

    srst_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .we       (bus_we),
        .word_idx (word_idx),
        .in_range (in_range),
        .wr_sel   (wr_sel)
    );

    generate
        for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_bank
            srst_reg #(.MASK_MODE(MASK_MODE), .PER(PER)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr_sel[g]),
                .wdata (bus_wdata),
                .bits  (flat[g*PER +: PER])
            );
        end
    endgenerate

    srst_rdmux #(.NUM_REGS(NUM_REGS), .PER(PER), .IDX_W(IDX_W)) u_rd (
        .flat     (flat),
        .word_idx (word_idx),
        .in_range (in_range),
        .rdata    (bus_rdata)
    );

    assign rst_out = flat;
endmodule

// File: rtl/srst_ctrl_chk.sv
`timescale 1ns/1ps
module srst_ctrl_chk #(
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned ADDR_W    = 8,
    parameter bit          MASK_MODE = 1'b1,
    localparam int unsigned PER      = MASK_MODE ? 16 : 32,
    localparam int unsigned IDX_W    = ADDR_W - 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [31:0]               bus_wdata,
    input logic                      bus_we,
    input logic [31:0]               bus_rdata,
    input logic [NUM_REGS*PER-1:0]   rst_out
);
    logic [IDX_W-1:0] chk_idx;
    logic             chk_valid;
    logic             chk_first;

    assign chk_idx   = bus_addr[ADDR_W-1:2];
    assign chk_valid = ({1'b0, chk_idx} < (IDX_W+1)'(NUM_REGS));
    assign chk_first = (chk_idx == '0);

    // R1
    rst_release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rst_out == '0));

    // R8
    oob_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !chk_valid) |=> $stable(rst_out));

    // R8
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> (bus_rdata == 32'h0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(rst_out));

    generate
        if (MASK_MODE) begin : g_mask_chk
            // R6
            upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdata[31:16] == 16'h0);
            // R3
            set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && chk_first && bus_wdata[16] && bus_wdata[0]) |=> rst_out[0]);
            // R4
            clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && chk_first && bus_wdata[16] && !bus_wdata[0]) |=> !rst_out[0]);
            // R5
            hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && !bus_wdata[16]) |=> $stable(rst_out[0]));
        end else begin : g_plain_chk
            // R7
            full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && chk_first) |=> (rst_out[31:0] == $past(bus_wdata)));
        end
    endgenerate
endmodule

bind srst_ctrl srst_ctrl_chk #(
    .NUM_REGS  (NUM_REGS),
    .ADDR_W    (ADDR_W),
    .MASK_MODE (MASK_MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .rst_out   (rst_out)
);

// File: tb/sim_srst_ctrl.sv
`timescale 1ns/1ps
module sim_srst_ctrl;
    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] rd_m, rd_p;
    logic [63:0]  out_m;
    logic [127:0] out_p;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    logic [31:0] m_reg [NR];
    logic [31:0] p_reg [NR];

    always #4 clk = ~clk;

    srst_ctrl #(.NUM_REGS(NR), .ADDR_W(8), .MASK_MODE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(rd_m), .rst_out(out_m));

    srst_ctrl #(.NUM_REGS(NR), .ADDR_W(8), .MASK_MODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(rd_p), .rst_out(out_p));

    // Reference model: behavioural, per-bit enable loop
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                m_reg[i] = '0;
                p_reg[i] = '0;
            end
        end else if (bus_we) begin
            int w;
            w = int'(bus_addr) / 4;
            if (w < NR) begin
                p_reg[w] = bus_wdata;
                for (int b = 0; b < 16; b++) begin
                    if (bus_wdata[b+16]) m_reg[w][b] = bus_wdata[b];
                end
            end
        end
    end

    task automatic check(string what, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic [63:0]  e_m;
            logic [127:0] e_p;
            logic [31:0]  er_m, er_p;
            int w;
            for (int n = 0; n < 64; n++)  e_m[n] = m_reg[n/16][n%16];
            for (int n = 0; n < 128; n++) e_p[n] = p_reg[n/32][n%32];
            w = int'(bus_addr) / 4;
            er_m = (w < NR) ? m_reg[w] : 32'h0;
            er_p = (w < NR) ? p_reg[w] : 32'h0;
            check("masked outputs", {64'h0, out_m}, {64'h0, e_m});
            check("plain outputs",  out_p, e_p);
            check("masked read", {96'h0, rd_m}, {96'h0, er_m});
            check("plain read",  {96'h0, rd_p}, {96'h0, er_p});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00); rd(8'h04);

        cur_req = "R3"; wr(8'h00, 32'h0001_0001);
        cur_req = "R2"; wr(8'h04, 32'h0080_0080);
        cur_req = "R5"; wr(8'h00, 32'h0000_FFFE); rd(8'h00);
        cur_req = "R4"; wr(8'h00, 32'h0001_0000); rd(8'h00);
        cur_req = "R6"; wr(8'h08, 32'hFFFF_FFFF); rd(8'h08);
        cur_req = "R10"; wr(8'h0C, 32'h8000_8000); rd(8'h04); rd(8'h08);
        cur_req = "R8"; wr(8'h10, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h10); rd(8'h14);
        cur_req = "R9"; wr(8'h0D, 32'h0004_0004); wr(8'h07, 32'h0100_0100); rd(8'h0E);

        cur_req = "R7";
        wr(8'h04, 32'h0000_00A0);
        rd(8'h04); v = rd_p; wr(8'h04, v | 32'h0000_0002);
        rd(8'h04); v = rd_p; wr(8'h04, v & ~32'h0000_0080);
        rd(8'h04);

        cur_req = "R2";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            bus_addr  = 8'($urandom_range(0, 23));
            bus_wdata = $urandom;
            bus_we    = ($urandom_range(0, 2) != 0);
        end
        @(negedge clk); bus_we = 1'b0;

        cur_req = "R1";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00);
        finish_run();
    end
endmodule